// File: doc/BRIEF.md
# Fixed-Latency Memory Response Emulator

This block stands in for external memory behind a cache. A requester presents one request per cycle: a write stores up to one line of 32-bit words into a small internal word array at once. A read takes a copy of the addressed words and parks it in a table of pending slots, where a countdown holds it back for a fixed number of cycles. When a slot's countdown has run out and the requester raises its fill-ready input, the slot's base address and line are returned on a one-cycle response and the slot is freed.

The emulator throttles the requester with a stall output. The stall is raised for one cycle in every fixed-length period, and also whenever the pending table has filled. A request presented while the stall is high is dropped without effect. Responses are not bound to request order: the lowest-numbered expired slot always wins, and a new read always takes the lowest-numbered free slot. A build parameter can switch the stall off entirely.

Top module: `lat_mem_emu`

## Requirements
- R1: While reset is held and in the first cycle after it, stall, rsp_valid, rsp_addr and rsp_data are all zero and the pending table is empty.
- R2: A read accepted at clock edge k, with fill_ready held high and no older expired slot, produces rsp_valid high after edge k+LATENCY (LATENCY=200 by default), carrying the request's base address and the stored words.
- R3: A request of N bytes covers N/4 words (capped at LINE_WORDS=4), word i at byte address base+4*i; word i travels on rsp_data[32*i+31:32*i] and req_wdata[32*i+31:32*i]; response words at or above N/4 are zero, and a write changes only its own N/4 words.
- R4: A write (req_write=1) updates storage at its accept edge, so a read accepted at any later edge sees it; a write never produces a response.
- R5: A read's data is captured at its accept edge; a write to the same address accepted later does not change the data that read returns.
- R6: A response is issued only at an edge where fill_ready is high and an expired slot exists, at most one per edge, and rsp_valid lasts one cycle; an expired slot waits for as long as fill_ready stays low; whenever rsp_valid is low, rsp_addr and rsp_data are zero.
- R7: A new read occupies the lowest-numbered free slot, and the response is taken from the lowest-numbered expired slot, so a younger read in a lower slot can be returned before an older one.
- R8: With the stall enabled, stall is high in the cycle after the first edge following reset and then every STALL_PERIOD=16 cycles, and low in the other cycles while the table is not full.
- R9: Stall is high in every cycle that follows an edge after which the table holds DEPTH=16 pending reads.
- R10: A request present at an edge where stall is high is ignored: a write does not change storage and a read creates no slot and no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte base address of the line |
| req_size | input | SIZE_W | Request size in bytes |
| req_wdata | input | LINE_WORDS*32 | Write words, word i in bits 32*i+31:32*i |
| stall | output | 1 | Requests at the next edge are dropped while high |
| fill_ready | input | 1 | Requester can take a response at this edge |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_addr | output | ADDR_W | Base address of the returned line, zero when idle |
| rsp_data | output | LINE_WORDS*32 | Returned words, zero when idle |

## Verification
A corrupted countdown shows up as a response that arrives one or more cycles off from the 200-cycle mark, or never, so the latency is measured edge by edge. A wrong slot choice appears as out-of-sequence addresses once several expired slots compete after fill_ready was held low, while a bad copy into a slot shows as a data miscompare on the very response that carries it. Faults in the stall counter or the occupancy count become visible within one stall period, either as a stall pulse in the wrong cycle or as a dropped or extra response when the table fills.

// File: rtl/lme_pkg.sv
package lme_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BYTE_OFS   = $clog2(WORD_BYTES);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } mem_op_e;

endpackage

// File: rtl/lme_store.sv
module lme_store
    import lme_pkg::*;
#(
    parameter int STORE_WORDS = 256,
    parameter int LINE_WORDS  = 4,
    localparam int IDX_W  = $clog2(STORE_WORDS),
    localparam int NW_W   = $clog2(LINE_WORDS + 1),
    localparam int LINE_W = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [NW_W-1:0]   nwords,
    input  logic [LINE_W-1:0] wdata,
    output logic [LINE_W-1:0] rdata
);

    word_t cells [STORE_WORDS];

    // one read lane per word of a line; lanes past the request length read as zero
    for (genvar lane = 0; lane < LINE_WORDS; lane++) begin : g_lane
        logic [IDX_W-1:0] lane_idx;
        logic             lane_on;
        assign lane_idx = word_idx + IDX_W'(lane);
        assign lane_on  = (NW_W'(lane) < nwords);
        assign rdata[lane*WORD_W +: WORD_W] = lane_on ? cells[lane_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < LINE_WORDS; w++) begin
                if (NW_W'(w) < nwords) begin
                    cells[word_idx + IDX_W'(w)] <= wdata[w*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/lme_throttle.sv
module lme_throttle #(
    parameter int STALL_EN     = 1,
    parameter int STALL_PERIOD = 16,
    parameter int DEPTH        = 16,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int PH_W  = $clog2(STALL_PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occ_next,
    output logic             stall
);

    if (STALL_EN != 0) begin : g_on
        typedef struct packed {
            logic [PH_W-1:0] phase;
            logic            flag;
        } thr_t;

        thr_t thr_q, thr_d;

        always_comb begin
            thr_d       = thr_q;
            thr_d.phase = (thr_q.phase == PH_W'(STALL_PERIOD - 1)) ? '0 : thr_q.phase + 1'b1;
            // periodic pulse, or the table will be full after this edge
            thr_d.flag  = (thr_q.phase == '0) || (occ_next >= OCC_W'(DEPTH));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q <= '0;
            end else begin
                thr_q <= thr_d;
            end
        end

        assign stall = thr_q.flag;
    end else begin : g_off
        assign stall = 1'b0;
    end

endmodule

// File: rtl/lme_pending.sv
module lme_pending
    import lme_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32,
    parameter int LATENCY    = 200,
    localparam int LINE_W = LINE_WORDS * WORD_W,
    localparam int CNT_W  = $clog2(LATENCY),
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              fill_ready,
    output logic              free_avail,
    output logic [OCC_W-1:0]  occ_next,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LINE_W-1:0] rsp_data
);

    typedef struct packed {
        logic              live;
        logic [CNT_W-1:0]  wait_cnt;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic              out_vld;
        logic [ADDR_W-1:0] out_addr;
        logic [LINE_W-1:0] out_line;
    } pend_t;

    pend_t pend_q, pend_d;

    logic              hit_found;
    logic [SLOT_W-1:0] hit_idx;
    logic              hole_found;
    logic [SLOT_W-1:0] hole_idx;
    logic              issue;
    logic [OCC_W-1:0]  occ;

    always_comb begin
        pend_d     = pend_q;
        hit_found  = 1'b0;
        hit_idx    = '0;
        hole_found = 1'b0;
        hole_idx   = '0;

        for (int i = 0; i < DEPTH; i++) begin
            if (pend_q.slot[i].live && (pend_q.slot[i].wait_cnt != '0)) begin
                pend_d.slot[i].wait_cnt = pend_q.slot[i].wait_cnt - 1'b1;
            end
            if (!hit_found && pend_q.slot[i].live && (pend_q.slot[i].wait_cnt == '0)) begin
                hit_found = 1'b1;
                hit_idx   = SLOT_W'(i);
            end
            if (!hole_found && !pend_q.slot[i].live) begin
                hole_found = 1'b1;
                hole_idx   = SLOT_W'(i);
            end
        end

        issue           = hit_found && fill_ready;
        pend_d.out_vld  = issue;
        pend_d.out_addr = issue ? pend_q.slot[hit_idx].addr : '0;
        pend_d.out_line = issue ? pend_q.slot[hit_idx].line : '0;
        if (issue) begin
            pend_d.slot[hit_idx].live = 1'b0;
        end

        // the hole was free before this edge, so it never collides with the issued slot
        if (alloc_en && hole_found) begin
            pend_d.slot[hole_idx].live     = 1'b1;
            pend_d.slot[hole_idx].wait_cnt = CNT_W'(LATENCY - 1);
            pend_d.slot[hole_idx].addr     = alloc_addr;
            pend_d.slot[hole_idx].line     = alloc_line;
        end

        occ = '0;
        for (int i = 0; i < DEPTH; i++) begin
            occ = occ + OCC_W'(pend_d.slot[i].live);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign free_avail = hole_found;
    assign occ_next   = occ;
    assign rsp_valid  = pend_q.out_vld;
    assign rsp_addr   = pend_q.out_addr;
    assign rsp_data   = pend_q.out_line;

endmodule

// File: rtl/lat_mem_emu.sv
module lat_mem_emu
    import lme_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LINE_WORDS   = 4,
    parameter int STORE_WORDS  = 256,
    parameter int DEPTH        = 16,
    parameter int LATENCY      = 200,
    parameter int STALL_EN     = 1,
    parameter int STALL_PERIOD = 16,
    localparam int LINE_W = LINE_WORDS * WORD_W,
    localparam int SIZE_W = $clog2(LINE_WORDS * WORD_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              stall,
    input  logic              fill_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LINE_W-1:0] rsp_data
);

    localparam int IDX_W = $clog2(STORE_WORDS);
    localparam int NW_W  = $clog2(LINE_WORDS + 1);
    localparam int OCC_W = $clog2(DEPTH + 1);

    mem_op_e           op;
    logic              taken;
    logic              wr_go;
    logic              rd_go;
    logic              free_avail;
    logic [OCC_W-1:0]  occ_next;
    logic [SIZE_W-1:0] size_words;
    logic [NW_W-1:0]   nwords;
    logic [LINE_W-1:0] snap_line;

    assign op         = mem_op_e'(req_write);
    assign taken      = req_valid && !stall;
    assign wr_go      = taken && (op == OP_WRITE);
    assign rd_go      = taken && (op == OP_READ) && free_avail;
    assign size_words = req_size >> BYTE_OFS;
    assign nwords     = (size_words > SIZE_W'(LINE_WORDS)) ? NW_W'(LINE_WORDS) : NW_W'(size_words);

    lme_store #(
        .STORE_WORDS(STORE_WORDS),
        .LINE_WORDS (LINE_WORDS)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_go),
        .word_idx(req_addr[BYTE_OFS +: IDX_W]),
        .nwords  (nwords),
        .wdata   (req_wdata),
        .rdata   (snap_line)
    );

    lme_pending #(
        .DEPTH     (DEPTH),
        .LINE_WORDS(LINE_WORDS),
        .ADDR_W    (ADDR_W),
        .LATENCY   (LATENCY)
    ) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (rd_go),
        .alloc_addr(req_addr),
        .alloc_line(snap_line),
        .fill_ready(fill_ready),
        .free_avail(free_avail),
        .occ_next  (occ_next),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data)
    );

    lme_throttle #(
        .STALL_EN    (STALL_EN),
        .STALL_PERIOD(STALL_PERIOD),
        .DEPTH       (DEPTH)
    ) u_throttle (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ_next(occ_next),
        .stall   (stall)
    );

endmodule

// File: rtl/lme_checker.sv
module lme_checker #(
    parameter int ADDR_W       = 32,
    parameter int LINE_W       = 128,
    parameter int DEPTH        = 16,
    parameter int STALL_EN     = 1,
    parameter int STALL_PERIOD = 16,
    localparam int OUT_W = $clog2(DEPTH + 2) + 1,
    localparam int PH_W  = $clog2(STALL_PERIOD)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              stall,
    input logic              fill_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [LINE_W-1:0] rsp_data
);

    logic [OUT_W-1:0] outstanding;
    logic [PH_W-1:0]  edge_ph;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            edge_ph     <= '0;
        end else begin
            outstanding <= outstanding
                         + OUT_W'(req_valid && !stall && !req_write)
                         - OUT_W'(rsp_valid);
            edge_ph     <= (edge_ph == PH_W'(STALL_PERIOD - 1)) ? '0 : edge_ph + 1'b1;
        end
    end

    // R6: idle response lines are zero
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_addr == '0 && rsp_data == '0));

    // R6: nothing is issued at an edge where the requester was not ready
    assert_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_ready |=> !rsp_valid);

    // R6: one-cycle response pulse only while fill_ready stays high is not required; a pulse never comes from an empty table
    assert_rsp_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (outstanding != '0));

    // R9: the table never holds more reads than it has slots
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= OUT_W'(DEPTH));

    // R8: periodic stall pulse after edges 1, 1+P, 1+2P, ...
    assert_period_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (STALL_EN != 0 && edge_ph == PH_W'(1)) |-> stall);

endmodule

bind lat_mem_emu lme_checker #(
    .ADDR_W      (ADDR_W),
    .LINE_W      (LINE_W),
    .DEPTH       (DEPTH),
    .STALL_EN    (STALL_EN),
    .STALL_PERIOD(STALL_PERIOD)
) u_lme_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .stall     (stall),
    .fill_ready(fill_ready),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data)
);

// File: tb/test_lat_mem_emu.sv
`timescale 1ns/1ps
module test_lat_mem_emu;

    localparam int LAT    = 200;
    localparam int DEPTH  = 16;
    localparam int LW     = 4;
    localparam int LINE_W = LW * 32;
    localparam int SZ_W   = 5;
    localparam int PERIOD = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [SZ_W-1:0]   req_size = '0;
    logic [LINE_W-1:0] req_wdata = '0;
    logic              stall;
    logic              fill_ready = 1'b0;
    logic              rsp_valid;
    logic [31:0]       rsp_addr;
    logic [LINE_W-1:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [256];

    always #10 clk = ~clk;

    lat_mem_emu i_lat_mem_emu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .stall(stall),
        .fill_ready(fill_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] model_line(input logic [31:0] a, input int nw);
        logic [LINE_W-1:0] l = '0;
        for (int i = 0; i < nw; i++) l[i*32 +: 32] = mdl[((a >> 2) + i) % 256];
        return l;
    endfunction

    function automatic logic [LINE_W-1:0] pat(input logic [31:0] seed);
        logic [LINE_W-1:0] l;
        for (int i = 0; i < LW; i++) l[i*32 +: 32] = seed * 32'h0101_0107 + 32'(i) * 32'h1111;
        return l;
    endfunction

    task automatic wait_free();
        @(negedge clk);
        while (stall) @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] a, input int nw, input logic [LINE_W-1:0] d);
        wait_free();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        req_size = SZ_W'(nw * 4); req_wdata = d;
        @(posedge clk); #2;
        req_valid = 1'b0;
        for (int i = 0; i < nw; i++) mdl[((a >> 2) + i) % 256] = d[i*32 +: 32];
    endtask

    task automatic do_read(input logic [31:0] a, input int bytes);
        wait_free();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        req_size = SZ_W'(bytes); req_wdata = '0;
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int limit, output logic got, output logic [31:0] a,
                            output logic [LINE_W-1:0] d, output int n);
        got = 1'b0; n = 0; a = '0; d = '0;
        while (!got && n < limit) begin
            @(posedge clk); n++; #1;
            if (rsp_valid) begin got = 1'b1; a = rsp_addr; d = rsp_data; end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 stall in reset", LINE_W'(stall), '0);
        check("R1 rsp_valid in reset", LINE_W'(rsp_valid), '0);
        check("R1 rsp_addr in reset", LINE_W'(rsp_addr), '0);
        check("R1 rsp_data in reset", rsp_data, '0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 stall after release", LINE_W'(stall), '0);
    endtask

    task automatic t_period();
        for (int e = 1; e <= 40; e++) begin
            @(posedge clk); #1;
            check($sformatf("R8 stall after edge %0d", e), LINE_W'(stall), LINE_W'((e - 1) % PERIOD == 0));
        end
    endtask

    task automatic t_latency();
        logic got; logic [31:0] a; logic [LINE_W-1:0] d; int n;
        fill_ready = 1'b1;
        do_write(32'h40, 4, pat(1));
        wait_rsp(LAT + 20, got, a, d, n);
        check("R4 write gives no response", LINE_W'(got), '0);
        do_read(32'h40, 16);
        wait_rsp(LAT + 20, got, a, d, n);
        check("R2 latency in edges", LINE_W'(n), LINE_W'(LAT));
        check("R2 response address", LINE_W'(a), LINE_W'(32'h40));
        check("R2 R4 response data", d, model_line(32'h40, 4));
        @(posedge clk); #1;
        check("R6 pulse lasts one cycle", LINE_W'(rsp_valid), '0);
    endtask

    task automatic t_size();
        logic got; logic [31:0] a; logic [LINE_W-1:0] d; int n;
        do_write(32'h80, 4, pat(2));
        do_write(32'h80, 2, pat(3));
        do_read(32'h80, 12);
        wait_rsp(LAT + 20, got, a, d, n);
        check("R3 partial write and partial read", d, model_line(32'h80, 3));
        check("R3 word 2 kept by short write", LINE_W'(d[64 +: 32]), LINE_W'(pat(2) >> 64) & LINE_W'(32'hFFFF_FFFF));
    endtask

    task automatic t_snapshot();
        logic got; logic [31:0] a; logic [LINE_W-1:0] d; int n;
        logic [LINE_W-1:0] old_line;
        do_write(32'hC0, 4, pat(4));
        old_line = model_line(32'hC0, 4);
        do_read(32'hC0, 16);
        do_write(32'hC0, 4, pat(5));
        wait_rsp(LAT + 20, got, a, d, n);
        check("R5 data captured at accept", d, old_line);
        do_read(32'hC0, 16);
        wait_rsp(LAT + 20, got, a, d, n);
        check("R4 R5 later read sees new data", d, model_line(32'hC0, 4));
    endtask

    task automatic t_backpressure();
        logic seen = 1'b0;
        logic nonzero = 1'b0;
        fill_ready = 1'b0;
        do_write(32'h100, 4, pat(6));
        do_read(32'h100, 16);
        for (int i = 0; i < LAT + 20; i++) begin
            @(posedge clk); #1;
            if (rsp_valid) seen = 1'b1;
            if (rsp_addr != 0 || rsp_data != 0) nonzero = 1'b1;
        end
        check("R6 no response while not ready", LINE_W'(seen), '0);
        check("R6 idle outputs zero", LINE_W'(nonzero), '0);
        @(negedge clk); fill_ready = 1'b1;
        @(posedge clk); #1;
        check("R6 held entry issued on ready", LINE_W'(rsp_valid), LINE_W'(1));
        check("R6 held entry address", LINE_W'(rsp_addr), LINE_W'(32'h100));
        check("R6 held entry data", rsp_data, model_line(32'h100, 4));
        @(posedge clk); #1;
        check("R6 idle valid after pulse", LINE_W'(rsp_valid), '0);
        check("R6 idle address after pulse", LINE_W'(rsp_addr), '0);
        check("R6 idle data after pulse", rsp_data, '0);
    endtask

    task automatic t_order();
        logic got; logic [31:0] a; logic [LINE_W-1:0] d; int n;
        do_write(32'h000, 4, pat(7));
        do_write(32'h010, 4, pat(8));
        do_write(32'h020, 4, pat(9));
        @(negedge clk); fill_ready = 1'b0;
        do_read(32'h000, 16);
        do_read(32'h010, 16);
        repeat (LAT + 10) @(posedge clk);
        @(negedge clk); fill_ready = 1'b1;
        @(posedge clk); #1;
        check("R7 first ready slot first", LINE_W'(rsp_addr), LINE_W'(32'h000));
        @(negedge clk); fill_ready = 1'b0;
        do_read(32'h020, 16);
        repeat (LAT + 10) @(posedge clk);
        @(negedge clk); fill_ready = 1'b1;
        wait_rsp(10, got, a, d, n);
        check("R7 younger read in lower slot wins", LINE_W'(a), LINE_W'(32'h020));
        check("R7 younger read data", d, model_line(32'h020, 4));
        wait_rsp(10, got, a, d, n);
        check("R7 older read follows", LINE_W'(a), LINE_W'(32'h010));
        check("R7 older read waited one edge", LINE_W'(n), LINE_W'(1));
    endtask

    task automatic t_full();
        int cnt = 0;
        logic stray = 1'b0;
        logic seq_ok = 1'b1;
        for (int i = 0; i < DEPTH; i++) do_write(32'h200 + 32'(16 * i), 4, pat(32'(20 + i)));
        @(negedge clk); fill_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) do_read(32'h200 + 32'(16 * i), 16);
        @(negedge clk);
        check("R9 stall when table full", LINE_W'(stall), LINE_W'(1));
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h300; req_size = SZ_W'(16);
        @(posedge clk); #2; req_valid = 1'b0;
        @(negedge clk); fill_ready = 1'b1;
        for (int i = 0; i < LAT + 60; i++) begin
            @(posedge clk); #1;
            if (rsp_valid) begin
                if (rsp_addr == 32'h300) stray = 1'b1;
                else if (rsp_addr != 32'h200 + 32'(16 * cnt) ||
                         rsp_data != model_line(rsp_addr, 4)) seq_ok = 1'b0;
                cnt++;
            end
        end
        check("R9 all queued reads returned", LINE_W'(cnt), LINE_W'(DEPTH));
        check("R7 R9 slot order and data", LINE_W'(seq_ok), LINE_W'(1));
        check("R10 read during full stall dropped", LINE_W'(stray), '0);
    endtask

    task automatic t_stall_ignore();
        logic got; logic [31:0] a; logic [LINE_W-1:0] d; int n;
        fill_ready = 1'b1;
        do_write(32'h380, 4, pat(40));
        @(negedge clk);
        while (!stall) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h380; req_size = SZ_W'(16); req_wdata = pat(41);
        @(posedge clk); #2; req_valid = 1'b0;
        do_read(32'h380, 16);
        wait_rsp(LAT + 20, got, a, d, n);
        check("R10 write during stall ignored", d, model_line(32'h380, 4));
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_period();
        t_latency();
        t_size();
        t_snapshot();
        t_backpressure();
        t_order();
        t_full();
        t_stall_ignore();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

endmodule